// File: doc/BRIEF.md
# Display-ID EEPROM mode controller

This block holds the mode logic of a small display-identification EEPROM that has two ways of talking to a host. After reset it is in transmit-only mode. In that mode it streams its stored bytes onto the SDA line, one bit per rising edge of a dedicated VCLK input. A shared address pointer walks through a 128-byte array and wraps around at the end. The SDA line is open-drain: the block only ever pulls it low, through `sda_pull_o`, and lets it float high otherwise.

When the host issues an I2C START and then a device-select byte whose upper seven bits match the configured address, the block leaves transmit-only mode. It enters a timed transition state, clears the pointer and the VCLK bit counter, and starts a recovery timer. The timer models a delay of about 2 seconds, and its length is a parameter. If a second matching select arrives before the timer runs out, the block commits to bidirectional I2C mode and stays there until reset. If the timer runs out first, the block falls back to transmit-only streaming, starting from address 0.

If VCLK stays low for too long during streaming, the block abandons the current byte and goes to a standby state. It resumes on the next VCLK edge. The read/write command engine sits outside this block and fills the array through a simple write port. It also reads the shared pointer.

Top module: `dispid_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (transmit-only), `ptr_o` is 0 and `sda_pull_o` is 0. Mode codes are: 0 transmit-only, 1 standby, 2 transition, 3 bidirectional.
- R2: In transmit-only mode, VCLK rising edges 1 to 8 of a byte frame present the byte at `ptr_o` most-significant bit first. A 0 bit sets `sda_pull_o` to 1 and a 1 bit sets it to 0, and the value holds until the next VCLK edge.
- R3: The ninth VCLK rising edge of a frame sets `sda_pull_o` to 0 and advances `ptr_o` by one.
- R4: The pointer wraps from 127 back to 0 after the byte at address 127 has been sent.
- R5: Every array byte reads as FFh after reset until it is written through the write port.
- R6: A START (SDA falling while SCL is high) followed by eight bits sampled on SCL rising edges, whose first seven bits are 1010000 (the eighth bit is ignored), moves the block from transmit-only or standby to transition mode. This sets `ptr_o` to 0. In transition mode, VCLK edges neither move `ptr_o` nor pull SDA.
- R7: A select byte whose first seven bits differ from 1010000 leaves the mode and `ptr_o` unchanged.
- R8: A second matching START and select received while in transition mode moves the block to bidirectional mode. It then stays there until reset, whatever VCLK and the timer do.
- R9: If RECOV_CYC clock cycles pass in transition mode without a second matching select, the block returns to transmit-only mode with `ptr_o` at 0. It does not return before then.
- R10: If VCLK stays low for VCLK_IDLE_CYC cycles in transmit-only mode, the block enters standby. It releases SDA and discards the partial frame. The next VCLK rising edge returns it to transmit-only mode and restarts the same byte from its most-significant bit.
- R11: A STOP (SDA rising while SCL is high) before the eighth select bit abandons the select. Bits that follow without a new START are not decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | I2C data line as seen on the wire, asynchronous |
| vclk_i | input | 1 | Transmit-only bit clock, asynchronous |
| wr_en_i | input | 1 | Write strobe from the command engine into the array |
| wr_addr_i | input | ADDR_W | Array write address |
| wr_data_i | input | DATA_W | Array write data |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mode_o | output | 2 | Current mode code (see R1) |
| ptr_o | output | ADDR_W | Shared address pointer |

## Verification
The stream is read back from a blank array (all ones, so no pulls at all) and from written bytes with mixed bit patterns, such as A5h and 3Ch. Patterns like these separate MSB-first order from LSB-first order and from a stuck line. A long walk through all 128 addresses reaches the wrap, and a byte cut short by a long VCLK-low gap shows that the frame restarts rather than continuing.

On the I2C side, the bench sends four kinds of select sequence: a matching select with the last bit set, a select that differs in one address bit, a select split by a STOP, and a repeated matching select. These separate a correct compare from one that ignores bits, and a STOP-aware decoder from one that is not. They also separate the commit to bidirectional mode from the timer fallback, whose deadline is probed just before and just after it expires.

// File: rtl/dispid_pkg.sv
// Shared types and constants for the display-ID EEPROM mode controller.
// Assumes a 2-bit mode code that is also visible on the top-level port.
package dispid_pkg;

    typedef enum logic [1:0] {
        MODE_TX      = 2'd0,
        MODE_STANDBY = 2'd1,
        MODE_TRANS   = 2'd2,
        MODE_BIDIR   = 2'd3
    } mode_e;

    // Bit positions of the pins inside the synchroniser vector
    localparam int PIN_N    = 3;
    localparam int PIN_VCLK = 0;
    localparam int PIN_SCL  = 1;
    localparam int PIN_SDA  = 2;

endpackage

// File: rtl/dispid_pin_sync.sv
// Two-flop synchroniser for N asynchronous pins, plus one extra delay stage
// so that the parent can form edges in the system clock domain.
// Assumes that each pin is slow compared with clk.
module dispid_pin_sync #(
    parameter int           N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] dly_o
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic meta_q, sync_q, dly_q;

        // Two-stage capture followed by one delay stage for edge forming
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
                dly_q  <= RST_VAL[g];
            end else begin
                meta_q <= pin_i[g];
                sync_q <= meta_q;
                dly_q  <= sync_q;
            end
        end

        assign lvl_o[g] = sync_q;
        assign dly_o[g] = dly_q;
    end

endmodule

// File: rtl/dispid_id_array.sv
// Byte array that models the ID memory. Every location is set to all ones
// on reset. There is one write port and a combinational read at the pointer.
// Assumes that write timing is handled by the command engine outside.
module dispid_id_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Blank-fill on reset, otherwise accept single-byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/dispid_vclk_tx.sv
// Transmit-only serialiser. A frame is DATA_W+1 VCLK rising edges: the
// first DATA_W edges shift the byte out MSB first, and the last one releases
// the line and reports frame_done. A VCLK-low watchdog reports idle.
// Assumes that vclk_rise_i is a one-cycle pulse in the clk domain.
module dispid_vclk_tx #(
    parameter int DATA_W   = 8,
    parameter int IDLE_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              idle_en_i,
    input  logic              clr_i,
    input  logic              vclk_lvl_i,
    input  logic              vclk_rise_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic              pull_o,
    output logic              frame_done_o,
    output logic              idle_o
);

    localparam int BW = $clog2(DATA_W + 1);
    localparam int IW = $clog2(IDLE_CYC + 1);

    logic [BW-1:0]     bitcnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              pull_q;
    logic [IW-1:0]     idle_q;
    logic              last_edge;

    assign last_edge = (bitcnt_q == BW'(DATA_W));

    // Bit counter, shift register and line driver
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            pull_q   <= 1'b0;
        end else if (en_i && vclk_rise_i) begin
            if (last_edge) begin
                bitcnt_q <= '0;
                pull_q   <= 1'b0;
            end else if (bitcnt_q == '0) begin
                pull_q   <= ~byte_i[DATA_W-1];
                shreg_q  <= byte_i << 1;
                bitcnt_q <= bitcnt_q + 1'b1;
            end else begin
                pull_q   <= ~shreg_q[DATA_W-1];
                shreg_q  <= shreg_q << 1;
                bitcnt_q <= bitcnt_q + 1'b1;
            end
        end
    end

    // Counts cycles of VCLK low while streaming
    always_ff @(posedge clk) begin
        if (!rst_n || !idle_en_i || vclk_lvl_i) begin
            idle_q <= '0;
        end else if (!idle_o) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign idle_o       = idle_en_i && !vclk_lvl_i && (idle_q == IW'(IDLE_CYC - 1));
    assign frame_done_o = en_i && vclk_rise_i && last_edge && !clr_i;
    assign pull_o       = pull_q;

endmodule

// File: rtl/dispid_sel_detect.sv
// Detects an I2C START and collects the next byte on SCL rising edges.
// It pulses done_o on the eighth bit, with hit_o high when the first
// seven bits equal DEV_ADDR. A STOP, or en_i low, abandons the collection.
// Assumes the inputs are already in the clk domain.
module dispid_sel_detect #(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic scl_lvl_i,
    input  logic scl_rise_i,
    input  logic sda_lvl_i,
    input  logic sda_rise_i,
    input  logic sda_fall_i,
    output logic done_o,
    output logic hit_o
);

    localparam int AW = $bits(DEV_ADDR);
    localparam int CW = $clog2(AW + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] shreg_q;
    logic          start_c, stop_c, last_c;

    assign start_c = scl_lvl_i && sda_fall_i;
    assign stop_c  = scl_lvl_i && sda_rise_i;
    assign last_c  = (cnt_q == CW'(AW));

    // Collection state: armed by START, cleared by STOP or by the last bit
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (start_c) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (stop_c) begin
            busy_q <= 1'b0;
        end else if (busy_q && scl_rise_i) begin
            shreg_q <= {shreg_q[AW-2:0], sda_lvl_i};
            cnt_q   <= cnt_q + 1'b1;
            if (last_c) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign done_o = en_i && busy_q && scl_rise_i && last_c && !start_c && !stop_c;
    assign hit_o  = (shreg_q == DEV_ADDR);

endmodule

// File: rtl/dispid_recov_timer.sv
// One-shot down-counter for the transition window. start_i loads it,
// cancel_i stops it, and expire_o pulses once when CYC cycles have elapsed.
// Assumes that CYC is at least 1.
module dispid_recov_timer #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cancel_i,
    output logic expire_o
);

    localparam int TW = $clog2(CYC + 1);

    logic [TW-1:0] cnt_q;
    logic          run_q;

    // Load, count down and stop
    always_ff @(posedge clk) begin
        if (!rst_n || cancel_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= TW'(CYC - 1);
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expire_o = run_q && (cnt_q == '0) && !start_i && !cancel_i;

endmodule

// File: rtl/dispid_mode_ctrl.sv
// Top of the display-ID EEPROM mode logic. It synchronises the pins, runs
// the four-state mode machine, owns the shared address pointer, and
// connects the serialiser, the select detector, the recovery timer and the
// byte array. Assumes that sda_i is the wired-AND value of the line.
module dispid_mode_ctrl
    import dispid_pkg::*;
#(
    parameter int         ADDR_W        = 7,
    parameter int         DATA_W        = 8,
    parameter int         RECOV_CYC     = 200_000_000,
    parameter int         VCLK_IDLE_CYC = 100_000,
    parameter logic [6:0] DEV_ADDR      = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              vclk_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              sda_pull_o,
    output logic [1:0]        mode_o,
    output logic [ADDR_W-1:0] ptr_o
);

    localparam logic [PIN_N-1:0] PIN_RST = (PIN_N'(1) << PIN_SDA) | (PIN_N'(1) << PIN_SCL);

    logic [PIN_N-1:0]  pin_vec, lvl, dly;
    logic              vclk_rise, scl_rise, sda_rise, sda_fall;
    logic [DATA_W-1:0] cur_byte;
    logic              tx_en, tx_idle_en, tx_clr, frame_done, idle_hit;
    logic              sel_en, sel_done, sel_hit_raw, sel_hit;
    logic              enter_trans, commit_bidir, expire;
    mode_e             mode_q, mode_d;
    logic [ADDR_W-1:0] ptr_q;

    assign pin_vec = {sda_i, scl_i, vclk_i};

    dispid_pin_sync #(.N(PIN_N), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_vec),
        .lvl_o (lvl),
        .dly_o (dly)
    );

    assign vclk_rise = lvl[PIN_VCLK] & ~dly[PIN_VCLK];
    assign scl_rise  = lvl[PIN_SCL]  & ~dly[PIN_SCL];
    assign sda_rise  = lvl[PIN_SDA]  & ~dly[PIN_SDA];
    assign sda_fall  = ~lvl[PIN_SDA] &  dly[PIN_SDA];

    // Mode-dependent enables and the events that link the sub-blocks
    assign tx_en        = (mode_q == MODE_TX) || (mode_q == MODE_STANDBY);
    assign tx_idle_en   = (mode_q == MODE_TX);
    assign sel_en       = (mode_q != MODE_BIDIR);
    assign sel_hit      = sel_done && sel_hit_raw;
    assign enter_trans  = sel_hit && tx_en;
    assign commit_bidir = sel_hit && (mode_q == MODE_TRANS);
    assign tx_clr       = enter_trans || idle_hit;

    dispid_id_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i),
        .waddr_i (wr_addr_i),
        .wdata_i (wr_data_i),
        .raddr_i (ptr_q),
        .rdata_o (cur_byte)
    );

    dispid_vclk_tx #(.DATA_W(DATA_W), .IDLE_CYC(VCLK_IDLE_CYC)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (tx_en),
        .idle_en_i    (tx_idle_en),
        .clr_i        (tx_clr),
        .vclk_lvl_i   (lvl[PIN_VCLK]),
        .vclk_rise_i  (vclk_rise),
        .byte_i       (cur_byte),
        .pull_o       (sda_pull_o),
        .frame_done_o (frame_done),
        .idle_o       (idle_hit)
    );

    dispid_sel_detect #(.DEV_ADDR(DEV_ADDR)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (sel_en),
        .scl_lvl_i  (lvl[PIN_SCL]),
        .scl_rise_i (scl_rise),
        .sda_lvl_i  (lvl[PIN_SDA]),
        .sda_rise_i (sda_rise),
        .sda_fall_i (sda_fall),
        .done_o     (sel_done),
        .hit_o      (sel_hit_raw)
    );

    dispid_recov_timer #(.CYC(RECOV_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (enter_trans),
        .cancel_i (commit_bidir),
        .expire_o (expire)
    );

    // Next-mode decision
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_TX: begin
                if (enter_trans)   mode_d = MODE_TRANS;
                else if (idle_hit) mode_d = MODE_STANDBY;
            end
            MODE_STANDBY: begin
                if (enter_trans)    mode_d = MODE_TRANS;
                else if (vclk_rise) mode_d = MODE_TX;
            end
            MODE_TRANS: begin
                if (commit_bidir) mode_d = MODE_BIDIR;
                else if (expire)  mode_d = MODE_TX;
            end
            MODE_BIDIR: mode_d = MODE_BIDIR;
            default:    mode_d = MODE_TX;
        endcase
    end

    // Mode register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_TX;
        else        mode_q <= mode_d;
    end

    // Shared address pointer: cleared on the select, stepped per frame
    always_ff @(posedge clk) begin
        if (!rst_n || enter_trans) ptr_q <= '0;
        else if (frame_done)       ptr_q <= ptr_q + 1'b1;
    end

    assign mode_o = mode_q;
    assign ptr_o  = ptr_q;

endmodule

// File: rtl/dispid_mode_chk.sv
// Port-level property checker for dispid_mode_ctrl, attached by bind.
module dispid_mode_chk
    import dispid_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_pull_o,
    input logic [1:0]        mode_o,
    input logic [ADDR_W-1:0] ptr_o
);

    // R8
    bidir_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_BIDIR) |=> (mode_o == MODE_BIDIR));

    // R6
    no_pull_off_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_TX) |-> !sda_pull_o);

    // R6
    trans_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_TRANS && $past(mode_o) != MODE_TRANS) |-> (ptr_o == '0));

    // R4
    ptr_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_TX && $past(mode_o) == MODE_TX) |->
        (ptr_o == $past(ptr_o) || ptr_o == ADDR_W'($past(ptr_o) + 1'b1)));

    // R9
    fallback_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_TX && $past(mode_o) == MODE_TRANS) |-> (ptr_o == '0));

    // R10
    standby_from_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_STANDBY && $past(mode_o) != MODE_STANDBY) |->
        ($past(mode_o) == MODE_TX));

endmodule

bind dispid_mode_ctrl dispid_mode_chk #(.ADDR_W(ADDR_W)) u_mode_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull_o (sda_pull_o),
    .mode_o     (mode_o),
    .ptr_o      (ptr_o)
);

// File: tb/dispid_mode_ctrl_bench.sv
// Directed bench for dispid_mode_ctrl: one task per scenario.
module dispid_mode_ctrl_bench;

    localparam int RECOV = 400;
    localparam int IDLE  = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b0;
    logic       host_sda = 1'b1;
    logic       vclk = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sda_pull;
    logic [1:0] mode;
    logic [6:0] ptr;
    logic       sda_line;

    int n_chk  = 0;
    int n_fail = 0;
    bit timeout = 0;

    always #5 clk = ~clk;

    assign sda_line = host_sda & ~sda_pull;

    dispid_mode_ctrl #(.RECOV_CYC(RECOV), .VCLK_IDLE_CYC(IDLE)) u_dispid_mode_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .vclk_i     (vclk),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .sda_pull_o (sda_pull),
        .mode_o     (mode),
        .ptr_o      (ptr)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic vclk_pulse(output logic pulled);
        vclk = 1'b1;
        step(6);
        pulled = sda_pull;
        vclk = 1'b0;
        step(6);
    endtask

    task automatic read_byte(output logic [7:0] b, output logic ninth);
        logic p;
        for (int i = 0; i < 8; i++) begin
            vclk_pulse(p);
            b[7-i] = ~p;
        end
        vclk_pulse(ninth);
    endtask

    task automatic mem_write(input logic [6:0] a, input logic [7:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        step(1);
        wr_en   = 1'b0;
    endtask

    task automatic i2c_start;
        host_sda = 1'b1; step(6);
        scl = 1'b1;      step(6);
        host_sda = 1'b0; step(6);
        scl = 1'b0;      step(6);
    endtask

    task automatic i2c_stop;
        host_sda = 1'b0; step(6);
        scl = 1'b1;      step(6);
        host_sda = 1'b1; step(6);
        scl = 1'b0;      step(6);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            host_sda = b[7-i]; step(6);
            scl = 1'b1;        step(6);
            scl = 1'b0;        step(6);
        end
    endtask

    task automatic t_reset;
        chk("R1 mode", int'(mode), 0);
        chk("R1 ptr", int'(ptr), 0);
        chk("R1 pull", int'(sda_pull), 0);
    endtask

    task automatic t_blank;
        logic [7:0] b;
        logic n9;
        read_byte(b, n9);
        chk("R5 blank byte", int'(b), 8'hFF);
        chk("R3 ninth release", int'(n9), 0);
        chk("R3 ptr step", int'(ptr), 1);
    endtask

    task automatic t_msb_first;
        logic [7:0] b;
        logic n9;
        read_byte(b, n9);
        chk("R2 byte A5", int'(b), 8'hA5);
        chk("R3 ninth release", int'(n9), 0);
        read_byte(b, n9);
        chk("R2 byte 3C", int'(b), 8'h3C);
        chk("R3 ptr after two", int'(ptr), 3);
    endtask

    task automatic t_wrap;
        logic [7:0] b;
        logic n9;
        bit all_ff = 1;
        for (int k = 3; k < 126; k++) begin
            read_byte(b, n9);
            if (b != 8'hFF) all_ff = 0;
        end
        chk("R5 unwritten run", int'(all_ff), 1);
        read_byte(b, n9);
        chk("R2 byte 126", int'(b), 8'h5A);
        read_byte(b, n9);
        chk("R2 byte 127", int'(b), 8'h81);
        chk("R4 wrap ptr", int'(ptr), 0);
        read_byte(b, n9);
        chk("R4 byte after wrap", int'(b), 8'hC3);
        chk("R4 ptr after wrap", int'(ptr), 1);
    endtask

    task automatic t_standby;
        logic p;
        logic [7:0] b;
        logic n9;
        vclk_pulse(p);
        vclk_pulse(p);
        chk("R2 partial bit", int'(p), 1);
        vclk_pulse(p);
        step(IDLE + 20);
        chk("R10 standby mode", int'(mode), 1);
        chk("R10 pull released", int'(sda_pull), 0);
        chk("R10 ptr held", int'(ptr), 1);
        vclk_pulse(p);
        chk("R10 resume mode", int'(mode), 0);
        chk("R10 restart msb", int'(p), 0);
        for (int i = 1; i < 8; i++) begin
            vclk_pulse(p);
            b[7-i] = ~p;
        end
        b[7] = 1'b1;
        vclk_pulse(n9);
        chk("R10 full byte", int'(b), 8'hA5);
        chk("R10 ptr once", int'(ptr), 2);
    endtask

    task automatic t_nomatch;
        i2c_start;
        send_bits(8'hA2, 8);
        step(6);
        chk("R7 mode not transition", int'(mode == 2'd2), 0);
        chk("R7 ptr kept", int'(ptr), 2);
        i2c_stop;
    endtask

    task automatic t_stop_abort;
        i2c_start;
        send_bits(8'hA0, 4);
        i2c_stop;
        send_bits(8'h00, 4);
        step(6);
        chk("R11 stop abandons", int'(mode == 2'd2), 0);
        chk("R11 ptr kept", int'(ptr), 2);
    endtask

    task automatic t_fallback;
        logic p;
        logic [7:0] b;
        logic n9;
        bit quiet = 1;
        i2c_start;
        send_bits(8'hA1, 8);
        chk("R6 enter transition", int'(mode), 2);
        chk("R6 ptr cleared", int'(ptr), 0);
        for (int i = 0; i < 9; i++) begin
            vclk_pulse(p);
            if (p) quiet = 0;
        end
        chk("R6 vclk no pull", int'(quiet), 1);
        chk("R6 vclk no step", int'(ptr), 0);
        step(210);
        chk("R9 not early", int'(mode), 2);
        step(80);
        chk("R9 back to stream", int'(mode), 0);
        chk("R9 ptr zero", int'(ptr), 0);
        read_byte(b, n9);
        chk("R9 stream from 0", int'(b), 8'hC3);
    endtask

    task automatic t_commit;
        logic p;
        bit quiet = 1;
        i2c_start;
        send_bits(8'hA0, 8);
        chk("R6 enter again", int'(mode), 2);
        i2c_start;
        send_bits(8'hA0, 8);
        chk("R8 commit", int'(mode), 3);
        step(RECOV + 100);
        chk("R8 sticky past timer", int'(mode), 3);
        for (int i = 0; i < 9; i++) begin
            vclk_pulse(p);
            if (p) quiet = 0;
        end
        chk("R8 vclk ignored", int'(quiet), 1);
        chk("R8 ptr held", int'(ptr), 0);
        chk("R8 still bidir", int'(mode), 3);
    endtask

    initial begin
        fork
            begin
                step(4);
                rst_n = 1'b1;
                step(1);
                t_reset;
                t_blank;
                mem_write(7'd0, 8'hC3);
                mem_write(7'd1, 8'hA5);
                mem_write(7'd2, 8'h3C);
                mem_write(7'd126, 8'h5A);
                mem_write(7'd127, 8'h81);
                t_msb_first;
                t_wrap;
                t_standby;
                t_nomatch;
                t_stop_abort;
                t_fallback;
                t_commit;
            end
            begin
                repeat (100_000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule